// File: doc/BRIEF.md
# Next-Page Exchange Management Registers

This block holds the management registers used when software steps through auto-negotiation next pages by hand. Software puts the next outgoing page into a transmit page register. The negotiation engine drops each incoming partner page into a receive page register. An expansion register carries a sticky page-arrived flag. Software polls that flag, and when it is set the receive register holds fresh partner data.

The flag holds until software reads the expansion register. It is also wiped when a new negotiation begins, so a leftover flag can never be paired with partner data from an earlier negotiation. The block also drives an exchange-enable output that is high only while both ends advertise next-page ability.

Access is through a plain register port. The read data is combinational from the address. A read strobe marks the cycle in which a read is consumed, and that strobe is what triggers clear-on-read.

Top module: `np_xchg_regs`

## Requirements
- R1: A synchronous active-high reset clears the transmit page, the receive page and the page-arrived flag to zero.
- R2: `np_xchg_en` is 1 exactly when `local_np_able` and `partner_np_able` are both 1.
- R3: A write to address 7 loads the transmit page only while `np_xchg_en` is 1; otherwise the write is ignored. Reading address 7 returns the transmit page.
- R4: A `pg_rcvd_pulse` loads `pg_rcvd_data` into the receive page at address 8. Without a pulse, that register holds its value, and writes to address 8 are ignored.
- R5: A `pg_rcvd_pulse` sets the flag, which reads at bit 1 of address 6. The flag stays set until a read strobe at address 6. That read returns 1, and from the next cycle on the flag reads 0.
- R6: When a page arrives in the same cycle as a read strobe at address 6, the set wins. The read returns the old flag value and the flag is 1 afterwards.
- R7: `neg_restart` clears the flag. It also wins over a simultaneous page arrival, which leaves the flag at 0. The receive page is still loaded in that case.
- R8: Address 6 bit 2 shows `local_np_able` and bit 3 shows `partner_np_able`. All other bits of address 6 read 0, and every unmapped address reads 0.
- R9: A read strobe at any address other than 6 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register address |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rd_en | input | 1 | Read strobe (marks a consumed read) |
| reg_rdata | output | 16 | Read data for the current address |
| pg_rcvd_pulse | input | 1 | One-cycle pulse when a partner page arrives |
| pg_rcvd_data | input | 16 | Partner page contents |
| neg_restart | input | 1 | Pulse when a new negotiation begins |
| local_np_able | input | 1 | Local side advertises next-page ability |
| partner_np_able | input | 1 | Partner advertises next-page ability |
| np_xchg_en | output | 1 | Next-page exchange enabled |

## Verification
Three sources can act on the flag in the same cycle: a page arrival, a clear-on-read of address 6, and a negotiation restart. Directed steps put a pulse together with a read of address 6, and a pulse together with a restart. In the first case the read must show the old value and the flag must read 1 afterwards. In the second case the flag must be 0 while the receive page still updates. Random traffic then mixes all three sources at high rates, and a bench model that gives the restart top priority, then the set, then the clear judges each cycle.

// File: rtl/np_xchg_pkg.sv
package np_xchg_pkg;
   localparam int EXP_FLAG_BIT = 1;
   localparam int EXP_LOC_BIT  = 2;
   localparam int EXP_PAR_BIT  = 3;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_EXP  = 2'd1,
      SEL_TX   = 2'd2,
      SEL_RX   = 2'd3
   } rd_sel_e;
endpackage

// File: rtl/np_page_reg.sv
module np_page_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= d;
   end

   AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(q)); // R4
endmodule

// File: rtl/np_page_flag.sv
module np_page_flag (
   input  logic clk,
   input  logic rst,
   input  logic set_pg,
   input  logic clr_rd,
   input  logic restart,
   output logic flag
);
   // priority: reset, restart, page set, clear-on-read
   always_ff @(posedge clk) begin
      if (rst)          flag <= 1'b0;
      else if (restart) flag <= 1'b0;
      else if (set_pg)  flag <= 1'b1;
      else if (clr_rd)  flag <= 1'b0;
   end

   AST_RESTART_CLR: assert property (@(posedge clk) disable iff (rst)
      restart |=> !flag); // R7
   AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      (set_pg && !restart) |=> flag); // R6
   AST_READ_CLR: assert property (@(posedge clk) disable iff (rst)
      (clr_rd && !set_pg && !restart) |=> !flag); // R5
   AST_STICKY: assert property (@(posedge clk) disable iff (rst)
      (flag && !clr_rd && !restart) |=> flag); // R9
   AST_RESET_CLR: assert property (@(posedge clk)
      rst |=> !flag); // R1
endmodule

// File: rtl/np_rd_mux.sv
module np_rd_mux
   import np_xchg_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  rd_sel_e           sel,
   input  logic              flag,
   input  logic              loc_able,
   input  logic              par_able,
   input  logic [DATA_W-1:0] tx_q,
   input  logic [DATA_W-1:0] rx_q,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] exp_word;

   always_comb begin
      exp_word              = '0;
      exp_word[EXP_FLAG_BIT] = flag;
      exp_word[EXP_LOC_BIT]  = loc_able;
      exp_word[EXP_PAR_BIT]  = par_able;
   end

   always_comb begin
      unique case (sel)
         SEL_EXP: rdata = exp_word;
         SEL_TX:  rdata = tx_q;
         SEL_RX:  rdata = rx_q;
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/np_xchg_regs.sv
module np_xchg_regs
   import np_xchg_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 16,
   parameter int EXP_ADDR = 6,
   parameter int TX_ADDR  = 7,
   parameter int RX_ADDR  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr_en,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_rd_en,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              pg_rcvd_pulse,
   input  logic [DATA_W-1:0] pg_rcvd_data,
   input  logic              neg_restart,
   input  logic              local_np_able,
   input  logic              partner_np_able,
   output logic              np_xchg_en
);
   localparam int ADDR_SPAN = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] A_EXP = ADDR_W'(EXP_ADDR);
   localparam logic [ADDR_W-1:0] A_TX  = ADDR_W'(TX_ADDR);
   localparam logic [ADDR_W-1:0] A_RX  = ADDR_W'(RX_ADDR);

   generate
      if (DATA_W <= EXP_PAR_BIT) begin : g_bad_width
         $error("DATA_W too narrow for expansion bits");
      end
      if (EXP_ADDR >= ADDR_SPAN || TX_ADDR >= ADDR_SPAN || RX_ADDR >= ADDR_SPAN) begin : g_bad_addr
         $error("register address outside ADDR_W range");
      end
      if (EXP_ADDR == TX_ADDR || EXP_ADDR == RX_ADDR || TX_ADDR == RX_ADDR) begin : g_dup_addr
         $error("register addresses must differ");
      end
   endgenerate

   logic              hit_exp, hit_tx, hit_rx;
   logic              tx_load, clr_rd, flag;
   logic [DATA_W-1:0] tx_q, rx_q;
   rd_sel_e           sel;

   assign np_xchg_en = local_np_able & partner_np_able;
   assign hit_exp    = (reg_addr == A_EXP);
   assign hit_tx     = (reg_addr == A_TX);
   assign hit_rx     = (reg_addr == A_RX);
   assign tx_load    = reg_wr_en & hit_tx & np_xchg_en;
   assign clr_rd     = reg_rd_en & hit_exp;

   always_comb begin
      if (hit_exp)     sel = SEL_EXP;
      else if (hit_tx) sel = SEL_TX;
      else if (hit_rx) sel = SEL_RX;
      else             sel = SEL_NONE;
   end

   np_page_reg #(.W(DATA_W)) u_tx (
      .clk(clk), .rst(rst), .load(tx_load), .d(reg_wdata), .q(tx_q));

   np_page_reg #(.W(DATA_W)) u_rx (
      .clk(clk), .rst(rst), .load(pg_rcvd_pulse), .d(pg_rcvd_data), .q(rx_q));

   np_page_flag u_flag (
      .clk(clk), .rst(rst), .set_pg(pg_rcvd_pulse), .clr_rd(clr_rd),
      .restart(neg_restart), .flag(flag));

   np_rd_mux #(.DATA_W(DATA_W)) u_mux (
      .sel(sel), .flag(flag), .loc_able(local_np_able), .par_able(partner_np_able),
      .tx_q(tx_q), .rx_q(rx_q), .rdata(reg_rdata));

   AST_TX_LOCKED: assert property (@(posedge clk) disable iff (rst)
      (reg_wr_en && hit_tx && !np_xchg_en) |=> $stable(tx_q)); // R3
   AST_RX_LOADS: assert property (@(posedge clk) disable iff (rst)
      pg_rcvd_pulse |=> (rx_q == $past(pg_rcvd_data))); // R4
   AST_PRECLEAR_VIEW: assert property (@(posedge clk) disable iff (rst)
      (clr_rd && flag) |-> reg_rdata[EXP_FLAG_BIT]); // R5
   AST_RESET_REGS: assert property (@(posedge clk)
      rst |=> (tx_q == '0 && rx_q == '0)); // R1
endmodule

// File: tb/np_xchg_regs_tb.sv
`timescale 1ns/1ps
module np_xchg_regs_tb;
   logic        clk = 1'b0;
   logic        rst;
   logic [4:0]  reg_addr;
   logic        reg_wr_en;
   logic [15:0] reg_wdata;
   logic        reg_rd_en;
   logic [15:0] reg_rdata;
   logic        pg_rcvd_pulse;
   logic [15:0] pg_rcvd_data;
   logic        neg_restart;
   logic        local_np_able;
   logic        partner_np_able;
   logic        np_xchg_en;

   int n_chk = 0;
   int n_bad = 0;

   logic [15:0] m_tx, m_rx;
   logic        m_flag;

   always #4 clk = ~clk;

   np_xchg_regs u_dut (
      .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
      .reg_wdata(reg_wdata), .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata),
      .pg_rcvd_pulse(pg_rcvd_pulse), .pg_rcvd_data(pg_rcvd_data),
      .neg_restart(neg_restart), .local_np_able(local_np_able),
      .partner_np_able(partner_np_able), .np_xchg_en(np_xchg_en));

   function automatic logic [15:0] exp_rd(input logic [4:0] a);
      logic [15:0] v = '0;
      case (a)
         5'd6: begin v[1] = m_flag; v[2] = local_np_able; v[3] = partner_np_able; end
         5'd7: v = m_tx;
         5'd8: v = m_rx;
         default: v = '0;
      endcase
      return v;
   endfunction

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic model_edge();
      if (rst) begin
         m_tx = '0; m_rx = '0; m_flag = 1'b0;
      end else begin
         if (reg_wr_en && reg_addr == 5'd7 && local_np_able && partner_np_able) m_tx = reg_wdata;
         if (pg_rcvd_pulse) m_rx = pg_rcvd_data;
         if (neg_restart)                          m_flag = 1'b0;
         else if (pg_rcvd_pulse)                   m_flag = 1'b1;
         else if (reg_rd_en && reg_addr == 5'd6)   m_flag = 1'b0;
      end
   endtask

   // inputs already driven after a negedge; check, then clock
   task automatic step(input string req);
      #1;
      check(req, reg_rdata, exp_rd(reg_addr));
      check("R2", {15'd0, np_xchg_en}, {15'd0, local_np_able & partner_np_able});
      @(posedge clk);
      model_edge();
      @(negedge clk);
   endtask

   task automatic idle_in();
      reg_wr_en = 0; reg_rd_en = 0; pg_rcvd_pulse = 0; neg_restart = 0;
      reg_wdata = '0; pg_rcvd_data = '0;
   endtask

   task automatic peek(input logic [4:0] a, input string req);
      idle_in(); reg_addr = a; step(req);
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      m_tx = '1; m_rx = '1; m_flag = 1'b1;
      rst = 1; idle_in(); reg_addr = 5'd0; local_np_able = 1; partner_np_able = 1;
      @(negedge clk);
      repeat (3) begin @(posedge clk); model_edge(); @(negedge clk); end
      rst = 0;
      // R1 reset state
      peek(5'd7, "R1"); peek(5'd8, "R1"); peek(5'd6, "R1");

      // R3 write enabled and disabled
      idle_in(); reg_addr = 5'd7; reg_wr_en = 1; reg_wdata = 16'hA5C3; step("R3");
      peek(5'd7, "R3");
      partner_np_able = 0;
      idle_in(); reg_addr = 5'd7; reg_wr_en = 1; reg_wdata = 16'h1111; step("R3");
      peek(5'd7, "R3");
      partner_np_able = 1;

      // R4 page load, write to 8 ignored
      idle_in(); pg_rcvd_pulse = 1; pg_rcvd_data = 16'h3C5A; reg_addr = 5'd8; step("R4");
      peek(5'd8, "R4");
      idle_in(); reg_addr = 5'd8; reg_wr_en = 1; reg_wdata = 16'hFFFF; step("R4");
      peek(5'd8, "R4");

      // R9 reads elsewhere keep flag, R8 unmapped reads zero
      idle_in(); reg_addr = 5'd8; reg_rd_en = 1; step("R9");
      idle_in(); reg_addr = 5'd13; reg_rd_en = 1; step("R8");
      peek(5'd6, "R9");

      // R5 read returns 1, then 0
      idle_in(); reg_addr = 5'd6; reg_rd_en = 1; step("R5");
      peek(5'd6, "R5");

      // R6 set and read together
      idle_in(); pg_rcvd_pulse = 1; pg_rcvd_data = 16'h0042; reg_addr = 5'd6; reg_rd_en = 1; step("R6");
      peek(5'd6, "R6");
      idle_in(); pg_rcvd_pulse = 1; pg_rcvd_data = 16'h0043; reg_addr = 5'd6; reg_rd_en = 1; step("R6");
      peek(5'd6, "R6");

      // R7 restart clears; restart with pulse
      idle_in(); neg_restart = 1; step("R7");
      peek(5'd6, "R7");
      idle_in(); neg_restart = 1; pg_rcvd_pulse = 1; pg_rcvd_data = 16'hBEEF; step("R7");
      peek(5'd6, "R7"); peek(5'd8, "R7");

      // R8 ability bits in register 6
      local_np_able = 0; partner_np_able = 1; peek(5'd6, "R8");
      local_np_able = 1; partner_np_able = 0; peek(5'd6, "R8");

      // random traffic
      void'($urandom(32'd2024));
      for (int i = 0; i < 4000; i++) begin
         int unsigned r = $urandom % 4;
         reg_addr        = (r == 0) ? 5'd6 : (r == 1) ? 5'd7 : (r == 2) ? 5'd8 : 5'($urandom);
         reg_wr_en       = ($urandom % 3) == 0;
         reg_rd_en       = ($urandom % 2) == 0;
         reg_wdata       = 16'($urandom);
         pg_rcvd_pulse   = ($urandom % 4) == 0;
         pg_rcvd_data    = 16'($urandom);
         neg_restart     = ($urandom % 10) == 0;
         local_np_able   = ($urandom % 4) != 0;
         partner_np_able = ($urandom % 4) != 0;
         step("R3 R4 R5 R6 R7 R8 R9 random");
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule